// File: doc/BRIEF.md
# Snooping Reservation Station Bank

This block is the waiting room in front of one floating-point execution unit. It has a small set of slots. Each slot holds one issued operation and its two source operands. When an operation issues, an operand may not be known yet. In that case the slot stores the tag of the station that will produce the value. Tag zero means the operand value is already present. While a slot waits, it watches a shared result broadcast bus. Any slot whose pending tag equals the broadcast tag copies the data and clears that tag. Several slots may do this in the same cycle.

Issue uses a valid/ready handshake. `iss_ready` stays high while at least one slot is free. An issue is accepted in a cycle with `iss_valid && iss_ready`, and `iss_tag` tells the issuer which station tag the new operation takes. Dispatch also uses a valid/ready handshake. Among the slots whose operands are both present, the oldest one is offered. Once offered, it stays offered with stable fields until `dsp_ready` accepts it. A dispatched slot stays occupied until the broadcast bus carries its own tag, which means its result has been written. The slot is free from the next cycle.

Top module: `rsb_station_bank`

## Requirements
- R1: After reset no slot is occupied: `iss_ready` is 1, `dsp_valid` is 0 and `iss_tag` equals BASE_TAG.
- R2: Slot i carries the fixed tag BASE_TAG+i, and tag 0 is never used by a slot. A new issue takes the lowest-numbered free slot, and `iss_tag` shows that slot's tag. `dsp_tag` shows the tag of the offered slot.
- R3: An issue is taken only when `iss_valid && iss_ready`. `iss_ready` is 0 exactly when every slot is occupied. An issue presented while `iss_ready` is 0 leaves no trace.
- R4: A producer tag of 0 marks the operand value as valid. A slot is offered for dispatch only when both of its producer tags are 0.
- R5: When `bc_valid` is 1 and `bc_tag` equals a waiting slot's nonzero producer tag, that operand takes `bc_data` and its tag becomes 0. Every matching slot captures in the same cycle.
- R6: A dispatched slot stays occupied until a broadcast carries its own tag. It is free in the following cycle.
- R7: Suppose an issued operand names tag T, and a broadcast of T happens in the same cycle. The operand then stores the broadcast data with tag 0.
- R8: When several slots are ready, the one issued earliest is offered. At most one slot is dispatched per cycle.
- R9: While `dsp_valid` is 1 and `dsp_ready` is 0, the offered slot and its `dsp_op`, `dsp_va`, `dsp_vb` and `dsp_tag` stay unchanged.
- R10: A broadcast whose tag matches no pending operand changes no waiting slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A slot is free |
| iss_op | input | OP_W | Operation code |
| iss_qa | input | TAG_W | Producer tag of operand A, 0 if the value is given |
| iss_va | input | DATA_W | Value of operand A |
| iss_qb | input | TAG_W | Producer tag of operand B, 0 if the value is given |
| iss_vb | input | DATA_W | Value of operand B |
| iss_tag | output | TAG_W | Tag the next accepted issue receives |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Producing station tag of the broadcast |
| bc_data | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A ready slot is offered |
| dsp_ready | input | 1 | Execution unit takes the offered slot |
| dsp_op | output | OP_W | Offered operation code |
| dsp_va | output | DATA_W | Offered operand A |
| dsp_vb | output | DATA_W | Offered operand B |
| dsp_tag | output | TAG_W | Tag of the offered slot |

## Verification
The assertions assume three things about the inputs. A broadcast never carries tag 0. A broadcast names one of this bank's own tags only after that slot has been dispatched. The issuer never asks a slot to wait on its own tag. The stimulus follows these rules: external producer tags are taken from values above the bank's tag range, and a slot's tag is broadcast only after the bench has accepted that slot at dispatch. Ordering is checked with a sequence in which a reused low-numbered slot ends up younger than a higher-numbered one. A single broadcast then releases all three slots together, so age order and index order give different results.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rsb_slot.sv
module rsb_slot
  import rsb_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 64,
  parameter int OP_W   = 3,
  parameter logic [TAG_W-1:0] MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [TAG_W-1:0]  alloc_qa,
  input  logic [DATA_W-1:0] alloc_va,
  input  logic [TAG_W-1:0]  alloc_qb,
  input  logic [DATA_W-1:0] alloc_vb,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              launch,
  output logic              busy,
  output logic              rdy,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] va_o,
  output logic [DATA_W-1:0] vb_o
);
  slot_state_e       state;
  logic [TAG_W-1:0]  qa, qb;
  logic [DATA_W-1:0] va, vb;
  logic [OP_W-1:0]   op;

  logic byp_a, byp_b, snoop_a, snoop_b, retire;

  assign byp_a   = bc_valid && (alloc_qa != '0) && (bc_tag == alloc_qa);
  assign byp_b   = bc_valid && (alloc_qb != '0) && (bc_tag == alloc_qb);
  assign snoop_a = (state == SLOT_WAIT) && (qa != '0) && bc_valid && (bc_tag == qa);
  assign snoop_b = (state == SLOT_WAIT) && (qb != '0) && bc_valid && (bc_tag == qb);
  assign retire  = (state == SLOT_EXEC) && bc_valid && (bc_tag == MY_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_IDLE;
      qa    <= '0;
      qb    <= '0;
      va    <= '0;
      vb    <= '0;
      op    <= '0;
    end else if (alloc) begin
      state <= SLOT_WAIT;
      op    <= alloc_op;
      qa    <= byp_a ? '0 : alloc_qa;
      va    <= byp_a ? bc_data : alloc_va;
      qb    <= byp_b ? '0 : alloc_qb;
      vb    <= byp_b ? bc_data : alloc_vb;
    end else begin
      case (state)
        SLOT_WAIT: begin
          if (snoop_a) begin
            qa <= '0;
            va <= bc_data;
          end
          if (snoop_b) begin
            qb <= '0;
            vb <= bc_data;
          end
          if (launch) state <= SLOT_EXEC;
        end
        SLOT_EXEC: if (retire) state <= SLOT_IDLE;
        default: state <= SLOT_IDLE;
      endcase
    end
  end

  assign busy = (state != SLOT_IDLE);
  assign rdy  = (state == SLOT_WAIT) && (qa == '0) && (qb == '0);
  assign op_o = op;
  assign va_o = va;
  assign vb_o = vb;

  assert_alloc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> state == SLOT_IDLE);
  assert_capture_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_a && !launch) |=> (qa == '0) && (va == $past(bc_data)));
  assert_capture_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_b && !launch) |=> (qb == '0) && (vb == $past(bc_data)));
  assert_launch_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (qa == '0) && (qb == '0) && (state == SLOT_WAIT));
  assert_retire_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> state == SLOT_IDLE);
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && byp_a) |=> (qa == '0) && (va == $past(bc_data)));
endmodule

// File: rtl/rsb_free_pick.sv
module rsb_free_pick #(
  parameter int N_SLOT = 3,
  localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic [N_SLOT-1:0] busy,
  output logic              any_free,
  output logic [IDX_W-1:0]  free_idx
);
  always_comb begin
    free_idx = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!busy[i]) free_idx = IDX_W'(i);
    end
  end
  assign any_free = ~&busy;
endmodule

// File: rtl/rsb_age_pick.sv
module rsb_age_pick #(
  parameter int N_SLOT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLOT-1:0] alloc_oh,
  input  logic [N_SLOT-1:0] busy,
  input  logic [N_SLOT-1:0] rdy,
  input  logic              take,
  output logic [N_SLOT-1:0] grant,
  output logic              any_grant
);
  logic [N_SLOT-1:0] older [N_SLOT];
  logic [N_SLOT-1:0] fresh;
  logic [N_SLOT-1:0] held_oh;
  logic              held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOT; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < N_SLOT; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < N_SLOT; j++) begin
            older[k][j] <= 1'b0;
            if (j != k) older[j][k] <= busy[j];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_SLOT; i++) begin
      fresh[i] = rdy[i];
      for (int j = 0; j < N_SLOT; j++) begin
        if (j != i && rdy[j] && older[j][i]) fresh[i] = 1'b0;
      end
    end
  end

  assign grant     = held ? held_oh : fresh;
  assign any_grant = |grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held    <= 1'b0;
      held_oh <= '0;
    end else if (any_grant && !take) begin
      held    <= 1'b1;
      held_oh <= grant;
    end else if (take) begin
      held    <= 1'b0;
    end
  end

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~rdy) == '0);
endmodule

// File: rtl/rsb_station_bank.sv
module rsb_station_bank #(
  parameter int N_SLOT   = 3,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int OP_W     = 3,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qa,
  input  logic [DATA_W-1:0] iss_va,
  input  logic [TAG_W-1:0]  iss_qb,
  input  logic [DATA_W-1:0] iss_vb,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_va,
  output logic [DATA_W-1:0] dsp_vb,
  output logic [TAG_W-1:0]  dsp_tag
);
  localparam int IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  logic [N_SLOT-1:0] busy, rdy, grant, alloc_oh, launch;
  logic [OP_W-1:0]   s_op [N_SLOT];
  logic [DATA_W-1:0] s_va [N_SLOT];
  logic [DATA_W-1:0] s_vb [N_SLOT];
  logic [IDX_W-1:0]  free_idx;
  logic              any_free, fire, take;

  rsb_free_pick #(.N_SLOT(N_SLOT)) u_free (
    .busy(busy), .any_free(any_free), .free_idx(free_idx));

  assign iss_ready = any_free;
  assign fire      = iss_valid && iss_ready;
  assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(free_idx);
  assign take      = dsp_valid && dsp_ready;

  generate
    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
      localparam logic [TAG_W-1:0] SLOT_TAG = TAG_W'(BASE_TAG + g);
      assign alloc_oh[g] = fire && (free_idx == IDX_W'(g));
      assign launch[g]   = grant[g] && dsp_ready;
      rsb_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .MY_TAG(SLOT_TAG)) u_slot (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_oh[g]),
        .alloc_op(iss_op), .alloc_qa(iss_qa), .alloc_va(iss_va),
        .alloc_qb(iss_qb), .alloc_vb(iss_vb),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .launch(launch[g]), .busy(busy[g]), .rdy(rdy[g]),
        .op_o(s_op[g]), .va_o(s_va[g]), .vb_o(s_vb[g]));
    end
  endgenerate

  rsb_age_pick #(.N_SLOT(N_SLOT)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_oh(alloc_oh), .busy(busy), .rdy(rdy),
    .take(take), .grant(grant), .any_grant(dsp_valid));

  always_comb begin
    dsp_op  = '0;
    dsp_va  = '0;
    dsp_vb  = '0;
    dsp_tag = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (grant[i]) begin
        dsp_op  = dsp_op  | s_op[i];
        dsp_va  = dsp_va  | s_va[i];
        dsp_vb  = dsp_vb  | s_vb[i];
        dsp_tag = dsp_tag | (TAG_W'(BASE_TAG) + TAG_W'(i));
      end
    end
  end

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> $countones(busy) <= $past($countones(busy)));
  assert_hold_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> dsp_valid && $stable(dsp_tag) && $stable(dsp_op)
      && $stable(dsp_va) && $stable(dsp_vb));
  assert_tag_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |-> dsp_tag != '0);
endmodule

// File: tb/rsb_station_bank_tb_top.sv
module rsb_station_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0, bc_valid = 1'b0, dsp_ready = 1'b0;
  logic [2:0]  iss_op = '0;
  logic [3:0]  iss_qa = '0, iss_qb = '0, bc_tag = '0;
  logic [63:0] iss_va = '0, iss_vb = '0, bc_data = '0;
  logic        iss_ready, dsp_valid;
  logic [3:0]  iss_tag, dsp_tag;
  logic [2:0]  dsp_op;
  logic [63:0] dsp_va, dsp_vb;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsb_station_bank dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_qa(iss_qa), .iss_va(iss_va), .iss_qb(iss_qb), .iss_vb(iss_vb),
    .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op), .dsp_va(dsp_va),
    .dsp_vb(dsp_vb), .dsp_tag(dsp_tag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] qa, input logic [63:0] va,
                       input logic [3:0] qb, input logic [63:0] vb);
    iss_valid = 1'b1; iss_op = op; iss_qa = qa; iss_va = va; iss_qb = qb; iss_vb = vb;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [63:0] d);
    bc_valid = 1'b1; bc_tag = t; bc_data = d;
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [3:0] t, input logic [2:0] op,
                      input logic [63:0] a, input logic [63:0] b);
    chk({req, " valid"}, 64'(dsp_valid), 64'd1);
    chk({req, " tag"}, 64'(dsp_tag), 64'(t));
    chk({req, " op"}, 64'(dsp_op), 64'(op));
    chk({req, " va"}, dsp_va, a);
    chk({req, " vb"}, dsp_vb, b);
    dsp_ready = 1'b1;
    tick();
    dsp_ready = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 iss_ready", 64'(iss_ready), 64'd1);
    chk("R1 dsp_valid", 64'(dsp_valid), 64'd0);
    chk("R1 iss_tag", 64'(iss_tag), 64'd1);

    // R2 R4 R6: sweep every op with ready operands through slot 0
    for (int op = 0; op < 8; op++) begin
      logic [63:0] a, b;
      a = 64'h0123_4567_89ab_cdef * 64'(op + 1);
      b = ~a + 64'(op * 17);
      chk("R2 iss_tag free", 64'(iss_tag), 64'd1);
      issue(3'(op), 4'd0, a, 4'd0, b);
      take("R4 sweep", 4'd1, 3'(op), a, b);
      chk("R8 one dispatch", 64'(dsp_valid), 64'd0);
      chk("R6 still held", 64'(iss_tag), 64'd2);
      bcast(4'd1, 64'hdead);
      chk("R6 freed", 64'(iss_tag), 64'd1);
    end

    // R3 fill, then ignored issue while full
    dsp_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R2 next tag", 64'(iss_tag), 64'(i + 1));
      issue(3'(i + 1), 4'd0, 64'(100 + i), 4'd0, 64'(200 + i));
    end
    chk("R3 full not ready", 64'(iss_ready), 64'd0);
    issue(3'd7, 4'd0, 64'hbad, 4'd0, 64'hbad);
    for (int i = 0; i < 3; i++) begin
      take("R3 full drain", 4'(i + 1), 3'(i + 1), 64'(100 + i), 64'(200 + i));
    end
    chk("R3 ignored issue left no slot", 64'(dsp_valid), 64'd0);
    for (int i = 0; i < 3; i++) bcast(4'(i + 1), 64'h0);
    chk("R3 ready again", 64'(iss_ready), 64'd1);

    // R7 bypass on A, R4 wait on B, R10 unmatched broadcast
    bc_valid = 1'b1; bc_tag = 4'd12; bc_data = 64'h1212_3434_5656_7878;
    issue(3'd5, 4'd12, 64'h0, 4'd13, 64'h0);
    bc_valid = 1'b0;
    chk("R4 waiting not offered", 64'(dsp_valid), 64'd0);
    bcast(4'd14, 64'hffff);
    chk("R10 unmatched ignored", 64'(dsp_valid), 64'd0);
    bcast(4'd13, 64'h0abc_0def);
    take("R7 R5 bypass then snoop", 4'd1, 3'd5, 64'h1212_3434_5656_7878, 64'h0abc_0def);
    bcast(4'd1, 64'h0);

    // R8 age order differs from index order; R5 shared capture; R9 hold
    issue(3'd1, 4'd10, 64'h0, 4'd0, 64'h11);   // slot tag 1, waits
    issue(3'd2, 4'd0, 64'h22, 4'd0, 64'h23);   // slot tag 2, ready
    issue(3'd3, 4'd0, 64'h33, 4'd10, 64'h0);   // slot tag 3, waits
    tick(); tick();
    take("R9 held offer", 4'd2, 3'd2, 64'h22, 64'h23);
    bcast(4'd2, 64'h0);
    chk("R2 reuse tag", 64'(iss_tag), 64'd2);
    issue(3'd4, 4'd10, 64'h0, 4'd10, 64'h0);   // slot tag 2, youngest
    chk("R4 none ready", 64'(dsp_valid), 64'd0);
    bcast(4'd10, 64'h5a5a_5a5a_0000_1010);
    take("R8 oldest first", 4'd1, 3'd1, 64'h5a5a_5a5a_0000_1010, 64'h11);
    take("R8 second oldest", 4'd3, 3'd3, 64'h33, 64'h5a5a_5a5a_0000_1010);
    take("R5 youngest both captured", 4'd2, 3'd4, 64'h5a5a_5a5a_0000_1010,
         64'h5a5a_5a5a_0000_1010);
    chk("R8 drained", 64'(dsp_valid), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule